// File: doc/BRIEF.md
# Memory Sleep Mode Sequencer

This block controls how a synchronous memory goes into and comes out of a low-power sleep state. A sleep request arrives with no timing relation to the clock. The block passes it through a two-flop synchronizer. It then runs a small state machine through four states: awake, a timed entry window, asleep, and a timed recovery window. The entry window and the recovery window each last two clock cycles by default.

The access engine reads several outputs from the sequencer:
- A blocking signal that stops array writes and forces the data outputs to tristate. This keeps the stored contents safe for the whole time the block is not awake.
- An abort signal, high during the entry window, that throws away any access still pending.
- An access-allowed signal, high only when the block is awake.

After wake-up, every chip enable and address strobe must stay inactive for the whole recovery window. If one of them becomes active in that window, the access is ignored and a sticky violation flag is raised. The flag stays set until reset.

Top module: `sleep_seq`

## Requirements
- R1: After reset the block is awake: `asleep`=0, `block_array`=0, `abort_access`=0, `recov_viol`=0, `access_ok`=1.
- R2: `sleep_req_async` passes through two synchronizer flops. Its rise is not acted on until the third rising clock edge after it is applied, so `block_array` stays 0 for two edges.
- R3: On that third edge the block starts the entry window. `block_array` and `abort_access` are both 1 for exactly ENTRY_CYC (2) cycles, and `asleep` is 1 after that.
- R4: While asleep with the request held, `asleep`=1, `block_array`=1, `abort_access`=0 and `access_ok`=0.
- R5: A fall of the request is also synchronized over two edges. On the third edge the block starts the recovery window, in which `block_array`=1, `asleep`=0 and `access_ok`=0. This lasts RECOV_CYC (2) cycles, and then the block is awake with `block_array`=0 and `access_ok`=1.
- R6: Any bit of `enable_act` or `strobe_act` at 1 (1 = active) during the recovery window sets `recov_viol` on the next edge. `access_ok` stays 0, so the access is ignored.
- R7: `recov_viol` stays 1 until reset.
- R8: Activity on `enable_act` or `strobe_act` while awake or asleep does not set `recov_viol`.
- R9: If the request drops during the entry window, the window still runs its full length. The block then reaches asleep before it starts recovery.
- R10: `access_ok` is never 1 while `block_array` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sleep_req_async | input | 1 | Sleep request, asynchronous to `clk` |
| enable_act | input | N_EN | Chip-enable activity, 1 = active |
| strobe_act | input | N_STB | Address-strobe activity, 1 = active |
| asleep | output | 1 | High while in the asleep state |
| block_array | output | 1 | Blocks array writes and tristates the data outputs |
| abort_access | output | 1 | Discards any pending access (entry window) |
| access_ok | output | 1 | The access engine may start accesses |
| recov_viol | output | 1 | Sticky flag for activity during recovery |

## Verification
A state register that is wrong shows at once at the ports. `block_array`, `asleep`, `abort_access` and `access_ok` are decoded straight from the state, so a wrong state or a missed transition changes at least one of them in the same cycle. A window counter that is off by one shows as an entry or recovery phase one cycle too short or too long. The bench counts these phases edge by edge from the moment the request changes. A lost or over-sensitive violation latch shows on `recov_viol` one edge after the offending activity.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE    = 2'd0,
    ST_ENTERING = 2'd1,
    ST_ASLEEP   = 2'd2,
    ST_RECOVER  = 2'd3
  } ss_state_e;
endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ss_timer.sv
module ss_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/ss_fsm.sv
module ss_fsm
  import ss_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int RECOV_CYC = 2,
  parameter int CW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_s,
  input  logic          win_done,
  output ss_state_e     state,
  output logic          win_load,
  output logic [CW-1:0] win_val
);
  localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 1);
  localparam logic [CW-1:0] RECOV_LAST = CW'(RECOV_CYC - 1);

  ss_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    win_load = 1'b0;
    win_val  = '0;
    unique case (state_q)
      ST_AWAKE: if (req_s) begin
        state_d  = ST_ENTERING;
        win_load = 1'b1;
        win_val  = ENTRY_LAST;
      end
      ST_ENTERING: if (win_done) state_d = ST_ASLEEP;
      ST_ASLEEP: if (!req_s) begin
        state_d  = ST_RECOVER;
        win_load = 1'b1;
        win_val  = RECOV_LAST;
      end
      ST_RECOVER: if (win_done) state_d = ST_AWAKE;
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_AWAKE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/ss_viol.sv
module ss_viol #(
  parameter int N_EN  = 3,
  parameter int N_STB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_recover,
  input  logic [N_EN-1:0]  enable_act,
  input  logic [N_STB-1:0] strobe_act,
  output logic             viol
);
  logic viol_q;
  logic set_en;

  assign set_en = in_recover && ((|enable_act) || (|strobe_act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      viol_q <= 1'b0;
    else if (set_en) viol_q <= 1'b1;
  end

  assign viol = viol_q;
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import ss_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int RECOV_CYC   = 2,
  parameter int N_EN        = 3,
  parameter int N_STB       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req_async,
  input  logic [N_EN-1:0]  enable_act,
  input  logic [N_STB-1:0] strobe_act,
  output logic             asleep,
  output logic             block_array,
  output logic             abort_access,
  output logic             access_ok,
  output logic             recov_viol
);
  localparam int WIN_MAX = (ENTRY_CYC > RECOV_CYC) ? ENTRY_CYC : RECOV_CYC;
  localparam int CW      = (WIN_MAX > 1) ? $clog2(WIN_MAX) : 1;

  logic          rst_n_s;
  logic          req_s;
  logic          win_done;
  logic          win_load;
  logic [CW-1:0] win_val;
  ss_state_e     state;

  // reset: asserted asynchronously, released after two edges
  ss_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_async(1'b1), .q_sync(rst_n_s)
  );

  ss_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n_s), .d_async(sleep_req_async), .q_sync(req_s)
  );

  ss_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .load(win_load), .load_val(win_val),
    .done(win_done)
  );

  ss_fsm #(.ENTRY_CYC(ENTRY_CYC), .RECOV_CYC(RECOV_CYC), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .req_s(req_s), .win_done(win_done),
    .state(state), .win_load(win_load), .win_val(win_val)
  );

  ss_viol #(.N_EN(N_EN), .N_STB(N_STB)) u_viol (
    .clk(clk), .rst_n(rst_n_s), .in_recover(state == ST_RECOVER),
    .enable_act(enable_act), .strobe_act(strobe_act), .viol(recov_viol)
  );

  assign asleep       = (state == ST_ASLEEP);
  assign block_array  = (state != ST_AWAKE);
  assign abort_access = (state == ST_ENTERING);
  assign access_ok    = (state == ST_AWAKE);
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk #(
  parameter int N_EN  = 3,
  parameter int N_STB = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EN-1:0]  enable_act,
  input logic [N_STB-1:0] strobe_act,
  input logic             asleep,
  input logic             block_array,
  input logic             abort_access,
  input logic             access_ok,
  input logic             recov_viol
);
  p_entry_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(block_array) |-> abort_access);

  p_entry_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_access && $past(abort_access)) |=> !abort_access);

  p_asleep_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (block_array && !access_ok && !abort_access));

  p_viol_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recov_viol) |-> $past(block_array && !asleep && !abort_access &&
                                ((|enable_act) || (|strobe_act))));

  p_viol_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recov_viol |=> recov_viol);

  p_gate_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    access_ok |-> !block_array);
endmodule

bind sleep_seq sleep_seq_chk #(.N_EN(N_EN), .N_STB(N_STB)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable_act(enable_act), .strobe_act(strobe_act),
  .asleep(asleep), .block_array(block_array), .abort_access(abort_access),
  .access_ok(access_ok), .recov_viol(recov_viol)
);

// File: tb/sleep_seq_tb.sv
module sleep_seq_tb;
  logic       clk;
  logic       rst_n;
  logic       req;
  logic [2:0] en;
  logic [1:0] stb;
  logic       asleep, block_array, abort_access, access_ok, recov_viol;
  int         checks;
  int         errors;
  bit         done;

  sleep_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req_async(req),
    .enable_act(en), .strobe_act(stb),
    .asleep(asleep), .block_array(block_array), .abort_access(abort_access),
    .access_ok(access_ok), .recov_viol(recov_viol)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // outputs packed as {asleep, block, abort, ok}
  function automatic int outs();
    return {asleep, block_array, abort_access, access_ok};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = 1'b0; en = '0; stb = '0;
    step(2);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic t_reset_r1();
    do_reset();
    chk("R1", "outputs", outs(), 4'b0001);
    chk("R1", "recov_viol", recov_viol, 0);
  endtask

  task automatic t_entry_r2_r3_r4();
    req = 1'b1;
    step(1); chk("R2", "edge1 block", block_array, 0);
    step(1); chk("R2", "edge2 block", block_array, 0);
    step(1); chk("R3", "entry1 outputs", outs(), 4'b0110);
    step(1); chk("R3", "entry2 outputs", outs(), 4'b0110);
    step(1); chk("R3", "after entry outputs", outs(), 4'b1100);
    en = 3'b101; stb = 2'b01;
    step(3); chk("R4", "held asleep outputs", outs(), 4'b1100);
    chk("R8", "viol after asleep activity", recov_viol, 0);
    en = '0; stb = '0;
  endtask

  task automatic t_exit_r5();
    req = 1'b0;
    step(2); chk("R5", "sync hold asleep", asleep, 1);
    step(1); chk("R5", "recover1 outputs", outs(), 4'b0100);
    step(1); chk("R5", "recover2 outputs", outs(), 4'b0100);
    step(1); chk("R5", "awake outputs", outs(), 4'b0001);
    chk("R5", "viol clean", recov_viol, 0);
  endtask

  task automatic t_awake_activity_r8();
    en = 3'b111; stb = 2'b11;
    step(3);
    chk("R8", "viol after awake activity", recov_viol, 0);
    chk("R8", "access_ok awake", access_ok, 1);
    en = '0; stb = '0;
  endtask

  task automatic t_violation_r6_r7();
    req = 1'b1; step(6);
    chk("R4", "asleep again", asleep, 1);
    req = 1'b0; step(3);
    chk("R6", "in recovery block", block_array, 1);
    stb = 2'b10;
    step(1);
    chk("R6", "viol set", recov_viol, 1);
    chk("R6", "access ignored", access_ok, 0);
    stb = '0;
    step(4);
    chk("R7", "viol sticky awake", recov_viol, 1);
    chk("R10", "awake gate", {block_array, access_ok}, 2'b01);
    do_reset();
    chk("R7", "viol cleared by reset", recov_viol, 0);
    // chip enable alone in the second recovery cycle
    req = 1'b1; step(6);
    req = 1'b0; step(4);
    en = 3'b010;
    step(1);
    chk("R6", "enable in recover2 sets viol", recov_viol, 1);
    en = '0;
    do_reset();
  endtask

  task automatic t_drop_during_entry_r9();
    req = 1'b1; step(3);
    chk("R9", "entering", abort_access, 1);
    req = 1'b0;
    step(1); chk("R9", "entry continues", abort_access, 1);
    step(1); chk("R9", "reaches asleep", outs(), 4'b1100);
    step(1); chk("R9", "then recovering", outs(), 4'b0100);
    step(2); chk("R9", "then awake", outs(), 4'b0001);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    t_reset_r1();
    t_entry_r2_r3_r4();
    t_exit_r5();
    t_awake_activity_r8();
    t_violation_r6_r7();
    t_drop_during_entry_r9();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule